// File: doc/BRIEF.md
# External Bus Idle-State Sequencer

This block steps external bus accesses through their bus states. It can also add one idle state when a read is directly followed by a write, so that a slow memory has time to release the data bus before the controller starts to drive it. Each access request carries a 32-bit address, a read/write flag and a flag that marks an access to an on-chip area. Every accepted access runs through T1 and then T2. When an idle state TI is needed, it is placed between the preceding read's T2 and the write's T1.

Whether an idle state is added is set for each of eight memory blocks by a 2-bit field in a 16-bit configuration register. The field that applies is the one for the block of the preceding read. The sequencer keeps a record of the last completed external cycle: whether it was a read, and which block it addressed. A reset or an access to an on-chip area clears this record. On-chip accesses never receive an idle state.

Requests use a valid/ready handshake. Ready is high only while the bus is idle, and a request is accepted on a clock edge where valid and ready are both high. While ready is low, the requester must hold valid, and keep the request fields unchanged, until ready returns. The configuration port is a plain 16-bit write strobe with a read-back bus.

Top module: `bus_idle_seq`

## Requirements
- R1: An accepted request that needs no idle state shows bus_state T1 (code 1) in the first cycle after acceptance, T2 (code 2) in the second, and idle-bus (code 0) in the third. Each state lasts exactly one cycle.
- R2: req_ready is high only when bus_state is idle-bus (code 0). While the bus is busy, a held request waits and is accepted only once the bus returns to idle.
- R3: An accepted external write enters TI (code 3) in the first cycle after acceptance, then T1, T2 and idle-bus, when three conditions hold: the last completed external cycle was a read, no on-chip access came after it, and the 2-bit field of that read's block holds 01.
- R4: Read-then-read, write-then-write and write-then-read sequences never produce TI.
- R5: The memory block of an access is req_addr[26:24]. The field for block n occupies cfg bits [2n+1:2n].
- R6: Field values 00, 10 and 11 all mean no idle state.
- R7: After reset, cfg_rdata is 0x5555, bus_state is idle-bus and req_ready is high.
- R8: An access with req_internal set never receives TI. It also clears the read record, so an external write that follows it receives no TI.
- R9: A cfg_wr_en pulse loads all 16 bits of cfg_wdata, and cfg_rdata shows them from the next cycle. Without a write the register holds its value.
- R10: The decision uses the field of the preceding read's block, not the field of the write's block.
- R11: The read record survives idle-bus cycles between accesses. A reset clears it, so the first write after reset gets no TI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | 32 | Access address; bits [26:24] select the memory block |
| req_write | input | 1 | 1 = write, 0 = read |
| req_internal | input | 1 | 1 = access to an on-chip area |
| cfg_wr_en | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 16 | Full-width configuration write value |
| cfg_rdata | output | 16 | Current configuration register contents |
| bus_state | output | 2 | 0 idle-bus, 1 T1, 2 T2, 3 TI |

## Verification
The assertions check the legal state steps on every cycle: T1 to T2, T2 to idle, TI to T1. They also check that ready is low while the bus is busy, that reads and on-chip accesses always start in T1, and that the register loads and holds as R9 requires. Other behaviour depends on history, and only the bench's scenarios can show it: the read record, which block's field is used (R10), reserved codes, the clearing effect of on-chip accesses, and record retention across idle gaps and reset. The bench tracks that history in a model and compares the exact state sequence of every transaction against it.

// File: rtl/bis_pkg.sv
package bis_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_T1   = 2'd1,
    BUS_T2   = 2'd2,
    BUS_TI   = 2'd3
  } bus_st_e;

  localparam logic [1:0] FLD_NONE = 2'b00;
  localparam logic [1:0] FLD_GAP  = 2'b01;
endpackage

// File: rtl/bis_cfg_reg.sv
module bis_cfg_reg #(
  parameter int NUM_BLK = 8,
  parameter int CFG_W   = 2 * NUM_BLK,
  parameter logic [CFG_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);
  // whole-register write only; no partial lanes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= wdata;
  end
endmodule

// File: rtl/bis_fld_lookup.sv
module bis_fld_lookup #(
  parameter int NUM_BLK = 8,
  parameter int BLK_W   = $clog2(NUM_BLK),
  parameter int CFG_W   = 2 * NUM_BLK
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic [BLK_W-1:0] blk,
  output logic             gap_en
);
  import bis_pkg::*;
  logic [NUM_BLK-1:0] en_vec;

  // only the exact "insert" code enables; reserved codes fall to no insertion
  for (genvar n = 0; n < NUM_BLK; n++) begin : g_fld
    assign en_vec[n] = (cfg[2*n +: 2] == FLD_GAP);
  end

  assign gap_en = en_vec[blk];
endmodule

// File: rtl/bis_seq.sv
module bis_seq #(
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_internal,
  input  logic [BLK_W-1:0] req_blk,
  input  logic             last_gap_en,
  output logic             req_ready,
  output logic [BLK_W-1:0] last_blk,
  output bis_pkg::bus_st_e st
);
  import bis_pkg::*;

  bus_st_e          nx;
  logic             accept;
  logic             need_gap;
  logic             last_rd;
  logic             cur_write;
  logic             cur_int;
  logic [BLK_W-1:0] cur_blk;

  assign req_ready = (st == BUS_IDLE);
  assign accept    = req_valid && req_ready;
  assign need_gap  = accept && req_write && !req_internal && last_rd && last_gap_en;

  always_comb begin
    nx = st;
    unique case (st)
      BUS_IDLE: if (accept) nx = need_gap ? BUS_TI : BUS_T1;
      BUS_TI:   nx = BUS_T1;
      BUS_T1:   nx = BUS_T2;
      BUS_T2:   nx = BUS_IDLE;
      default:  nx = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= BUS_IDLE;
    else        st <= nx;
  end

  // capture the accepted access for the record update at its T2
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_write <= 1'b0;
      cur_int   <= 1'b0;
      cur_blk   <= '0;
    end else if (accept) begin
      cur_write <= req_write;
      cur_int   <= req_internal;
      cur_blk   <= req_blk;
    end
  end

  // record of the last completed external cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_rd  <= 1'b0;
      last_blk <= '0;
    end else if (st == BUS_T2) begin
      if (cur_int) begin
        last_rd <= 1'b0;
      end else begin
        last_rd  <= !cur_write;
        last_blk <= cur_blk;
      end
    end
  end
endmodule

// File: rtl/bus_idle_seq.sv
module bus_idle_seq #(
  parameter int ADDR_W  = 32,
  parameter int NUM_BLK = 8,
  parameter int BLK_LSB = 24,
  parameter logic [2*NUM_BLK-1:0] CFG_RST = 16'h5555
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_write,
  input  logic                   req_internal,
  input  logic                   cfg_wr_en,
  input  logic [2*NUM_BLK-1:0]   cfg_wdata,
  output logic [2*NUM_BLK-1:0]   cfg_rdata,
  output logic [1:0]             bus_state
);
  localparam int BLK_W = $clog2(NUM_BLK);
  localparam int CFG_W = 2 * NUM_BLK;

  logic [BLK_W-1:0] req_blk;
  logic [BLK_W-1:0] last_blk;
  logic             last_gap_en;
  logic             addr_unused;
  bis_pkg::bus_st_e st;

  assign req_blk     = req_addr[BLK_LSB +: BLK_W];
  assign addr_unused = ^req_addr;

  bis_cfg_reg #(.NUM_BLK(NUM_BLK), .CFG_W(CFG_W), .RST_VAL(CFG_RST)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr_en),
    .wdata (cfg_wdata),
    .q     (cfg_rdata)
  );

  bis_fld_lookup #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W), .CFG_W(CFG_W)) u_lookup (
    .cfg    (cfg_rdata),
    .blk    (last_blk),
    .gap_en (last_gap_en)
  );

  bis_seq #(.BLK_W(BLK_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_internal (req_internal),
    .req_blk      (req_blk),
    .last_gap_en  (last_gap_en),
    .req_ready    (req_ready),
    .last_blk     (last_blk),
    .st           (st)
  );

  assign bus_state = st;
endmodule

// File: rtl/bus_idle_seq_chk.sv
module bus_idle_seq_chk #(
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             req_internal,
  input logic             cfg_wr_en,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic [1:0]       bus_state
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_t1_to_t2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 2'd1 |=> bus_state == 2'd2);
  assert_t2_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 2'd2 |=> bus_state == 2'd0);
  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state != 2'd0 |-> !req_ready);
  assert_idle_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 2'd0 && !req_valid) |=> bus_state == 2'd0);
  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (bus_state == 2'd1 || bus_state == 2'd3));
  assert_ti_to_t1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 2'd3 |=> bus_state == 2'd1);
  assert_read_no_ti_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> bus_state == 2'd1);
  assert_internal_no_ti_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_internal) |=> bus_state == 2'd1);
  assert_cfg_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rdata == $past(cfg_wdata));
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(cfg_rdata));
endmodule

bind bus_idle_seq bus_idle_seq_chk #(.CFG_W(2*NUM_BLK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_internal (req_internal),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .bus_state    (bus_state)
);

// File: tb/bus_idle_seq_bench.sv
`timescale 1ns/1ps
module bus_idle_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_internal = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [1:0]  bus_state;

  int checks = 0;
  int fails  = 0;

  // reference model state
  bit       m_last_rd  = 1'b0;
  bit [2:0] m_last_blk = 3'd0;
  bit [15:0] m_cfg     = 16'h5555;

  always #4 clk = ~clk;

  bus_idle_seq u_bus_idle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_internal(req_internal),
    .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bus_state(bus_state)
  );

  task automatic check(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_gap(input bit wr, input bit intl);
    return wr && !intl && m_last_rd && (m_cfg[2*m_last_blk +: 2] == 2'b01);
  endfunction

  function automatic void model_done(input bit wr, input bit intl, input bit [2:0] blk);
    if (intl) m_last_rd = 1'b0;
    else begin
      m_last_rd  = !wr;
      m_last_blk = blk;
    end
  endfunction

  function automatic logic [31:0] mk_addr(input bit [2:0] blk);
    logic [31:0] a;
    a = $urandom;
    a[26:24] = blk;
    return a;
  endfunction

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    cfg_wdata = ~v;
    m_cfg = v;
    check(cfg_rdata, v, "R9", "register read-back");
  endtask

  // one access; the TI expectation is tagged with the requirement under test
  task automatic run_req(input bit [2:0] blk, input bit wr, input bit intl, input string req);
    bit g;
    g = exp_gap(wr, intl);
    @(negedge clk);
    req_valid    = 1'b1;
    req_addr     = mk_addr(blk);
    req_write    = wr;
    req_internal = intl;
    check(req_ready, 1, "R2", "ready while idle");
    @(negedge clk);
    req_valid = 1'b0;
    check(bus_state == 2'd3, g, req, "TI presence");
    if (g) @(negedge clk);
    check(bus_state, 1, "R1", "T1 state");
    check(req_ready, 0, "R2", "ready in T1");
    @(negedge clk);
    check(bus_state, 2, "R1", "T2 state");
    @(negedge clk);
    check(bus_state, 0, "R1", "back to idle");
    model_done(wr, intl, blk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rdata, 16'h5555, "R7", "reset cfg value");
    check(bus_state, 0, "R7", "reset state");
    check(req_ready, 1, "R7", "reset ready");

    // R11: cleared record, so first write after reset gets no TI
    run_req(3'd2, 1'b1, 1'b0, "R11");
    // R3: read then write in enabled block
    run_req(3'd2, 1'b0, 1'b0, "R3");
    run_req(3'd2, 1'b1, 1'b0, "R3");
    // R4 orderings
    run_req(3'd4, 1'b1, 1'b0, "R4");
    run_req(3'd4, 1'b0, 1'b0, "R4");
    run_req(3'd4, 1'b0, 1'b0, "R4");
    // R5: field position, block 6 only enabled
    cfg_write(16'h1000);
    run_req(3'd6, 1'b0, 1'b0, "R5");
    run_req(3'd6, 1'b1, 1'b0, "R5");
    run_req(3'd5, 1'b0, 1'b0, "R5");
    run_req(3'd5, 1'b1, 1'b0, "R5");
    // R6: reserved and zero codes in block 2
    cfg_write(16'h0020);
    run_req(3'd2, 1'b0, 1'b0, "R6");
    run_req(3'd2, 1'b1, 1'b0, "R6");
    cfg_write(16'h0030);
    run_req(3'd2, 1'b0, 1'b0, "R6");
    run_req(3'd2, 1'b1, 1'b0, "R6");
    cfg_write(16'h0000);
    run_req(3'd2, 1'b0, 1'b0, "R6");
    run_req(3'd2, 1'b1, 1'b0, "R6");
    // R10: block 1 enabled, block 5 not
    cfg_write(16'h0004);
    run_req(3'd5, 1'b0, 1'b0, "R10");
    run_req(3'd1, 1'b1, 1'b0, "R10");
    run_req(3'd1, 1'b0, 1'b0, "R10");
    run_req(3'd5, 1'b1, 1'b0, "R10");
    // R8: internal accesses
    cfg_write(16'h5555);
    run_req(3'd0, 1'b0, 1'b0, "R8");
    run_req(3'd0, 1'b1, 1'b1, "R8");
    run_req(3'd0, 1'b0, 1'b0, "R8");
    run_req(3'd0, 1'b0, 1'b1, "R8");
    run_req(3'd0, 1'b1, 1'b0, "R8");
    // R11: idle gap keeps the record
    run_req(3'd7, 1'b0, 1'b0, "R11");
    repeat (6) @(negedge clk);
    run_req(3'd7, 1'b1, 1'b0, "R11");

    // R2: write held while a read is in progress
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk_addr(3'd3); req_write = 1'b0; req_internal = 1'b0;
    @(negedge clk);
    req_addr = mk_addr(3'd3); req_write = 1'b1;
    check(bus_state, 1, "R2", "read T1");
    check(req_ready, 0, "R2", "held write stalled in T1");
    @(negedge clk);
    check(req_ready, 0, "R2", "held write stalled in T2");
    @(negedge clk);
    check(bus_state, 0, "R2", "idle before accept");
    check(req_ready, 1, "R2", "ready at idle");
    @(negedge clk);
    req_valid = 1'b0;
    check(bus_state, 3, "R3", "TI after held write accepted");
    @(negedge clk);
    check(bus_state, 1, "R1", "T1 after TI");
    @(negedge clk);
    check(bus_state, 2, "R1", "T2 after TI");
    @(negedge clk);
    check(bus_state, 0, "R1", "idle after held write");
    model_done(1'b1, 1'b0, 3'd3);

    // constrained random traffic
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 16) == 0) cfg_write(16'($urandom));
      run_req(3'($urandom), 1'($urandom), (($urandom % 8) == 0), "R3");
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule